// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal one another about messages that they place in a shared memory. The memory and the message layout are kept outside the block. The block holds only the handshake state: six occupancy flags for the processor-1-to-processor-2 direction and six for the reverse direction.

The sender of a direction sets a flag once its message is in memory. The receiver clears that flag once it has consumed the message. Each processor has its own interrupt enables, per-channel masks and a write-one set/clear register. From these the block derives four level interrupts: for each processor, a "transmit slot free" line and a "receive slot occupied" line.

Both processors reach the block through one 32-bit memory-mapped slave port, which works in the style of a reduced AHB access. Read data is combinational in the same cycle as the request, and writes take effect at the clock edge that samples them.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset, every flag reads 0 (free), both control registers read 0x00000000, both mask registers read 0x003F003F, and all four interrupts are low.
- R2: A word write of 1 to bit 16+n of a processor's set/clear register (0x008 for P1, 0x018 for P2) sets channel n of that processor's own transmit status. Bits written as 0 have no effect.
- R3: A word write of 1 to bit n of a processor's set/clear register clears channel n of the opposite processor's transmit status. That status is this processor's receive status.
- R4: Reads of either set/clear register return 0.
- R5: The status registers are read-only. P1-to-P2 is at 0x00C and P2-to-P1 is at 0x01C, both in bits 5:0, and writes to them change nothing.
- R6: A processor's TX-free interrupt is high when its control bit 16 is 1 and some channel of its own transmit status is 0 with that channel's free mask bit (mask register bit 16+n) at 0.
- R7: A processor's RX-occupied interrupt is high when its control bit 0 is 1 and some channel of the opposite transmit status is 1 with that channel's occupied mask bit (mask register bit n) at 0.
- R8: Each interrupt output is registered. It reflects a flag, mask or enable change one clock after that change becomes visible in the registers.
- R9: A write whose size code is not word (size 3'b010) has no effect on any register or flag.
- R10: The control registers (P1 at 0x000, P2 at 0x010) and the mask registers (P1 at 0x004, P2 at 0x014) read back their stored bits. Reserved bits read 0 and ignore writes.
- R11: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 3 | Access size code; 3'b010 = 32-bit word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| p1_txfree_irq | output | 1 | Processor 1 transmit-free interrupt |
| p1_rxocc_irq | output | 1 | Processor 1 receive-occupied interrupt |
| p2_txfree_irq | output | 1 | Processor 2 transmit-free interrupt |
| p2_rxocc_irq | output | 1 | Processor 2 receive-occupied interrupt |

## Verification
Several properties are checked on every cycle:
- Each of the four interrupts equals its enable-mask-flag equation one cycle earlier.
- A flag rises only after a set write from its sender and falls only after a clear write from its receiver.
- Narrow writes and writes to the status registers leave the flags untouched.
- Set/clear reads return zero.

Only the bench's scenarios show register readback and reserved-bit filtering, reset values, unmapped reads, and the end-to-end exchange in which one processor posts, the other sees the occupied interrupt and frees the slot, and the sender's free interrupt returns.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Register slot within one processor's four-word group (address bits 3:2).
    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_MASK = 2'd1,
        SLOT_SETCLR = 2'd2,
        SLOT_STATUS = 2'd3
    } slot_e;

    localparam logic [2:0] SIZE_WORD = 3'b010;
    localparam int HI_LSB = 16;  // upper field: TX enable, free masks, set bits
    localparam int LO_LSB = 0;   // lower field: RX enable, occupied masks, clear bits
endpackage

// File: rtl/mbx_chan_flags.sv
module mbx_chan_flags #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] flag_o
);
    logic [NCH-1:0] flag_d, flag_q;

    // A set and a clear that land in the same cycle: the set wins.
    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
    parameter int NCH = 6,
    parameter bit FIRE_ON_SET = 1'b1  // 1: occupied-style, 0: free-style
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [NCH-1:0] mask_i,
    input  logic [NCH-1:0] flag_i,
    output logic           irq_o
);
    logic [NCH-1:0] hit;
    logic irq_d, irq_q;

    generate
        if (FIRE_ON_SET) begin : g_occ
            assign hit = flag_i & ~mask_i;
        end else begin : g_free
            assign hit = ~flag_i & ~mask_i;
        end
    endgenerate

    always_comb begin
        irq_d = en_i & (|hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl
    import mbx_pkg::*;
#(
    parameter int NCH = 6,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [2:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              p1_txfree_irq,
    output logic              p1_rxocc_irq,
    output logic              p2_txfree_irq,
    output logic              p2_rxocc_irq
);
    localparam int NPROC = 2;
    localparam int MAP_BITS = 5;  // 8 words = 32 bytes

    typedef struct packed {
        logic [NPROC-1:0]          tx_en;
        logic [NPROC-1:0]          rx_en;
        logic [NPROC-1:0][NCH-1:0] fm;
        logic [NPROC-1:0][NCH-1:0] om;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Direction d carries processor d's transmit flags (0: P1->P2, 1: P2->P1).
    logic [NPROC-1:0][NCH-1:0] set_v, clr_v, flags_w;
    logic [NPROC-1:0]          tx_en_w, rx_en_w, irq_tx_w, irq_rx_w;
    logic [NPROC-1:0][NCH-1:0] fm_w, om_w;

    logic  in_map, word_wr, proc;
    slot_e slot;

    assign in_map  = bus_sel && (bus_addr[ADDR_W-1:MAP_BITS] == '0) && (bus_addr[1:0] == 2'b00);
    assign word_wr = in_map && bus_write && (bus_size == SIZE_WORD);
    assign proc    = bus_addr[4];
    assign slot    = slot_e'(bus_addr[3:2]);

    always_comb begin
        cfg_d = cfg_q;
        set_v = '0;
        clr_v = '0;
        if (word_wr) begin
            case (slot)
                SLOT_CTRL: begin
                    cfg_d.tx_en[proc] = bus_wdata[HI_LSB];
                    cfg_d.rx_en[proc] = bus_wdata[LO_LSB];
                end
                SLOT_MASK: begin
                    cfg_d.fm[proc] = bus_wdata[HI_LSB +: NCH];
                    cfg_d.om[proc] = bus_wdata[LO_LSB +: NCH];
                end
                SLOT_SETCLR: begin
                    set_v[proc]  = bus_wdata[HI_LSB +: NCH];
                    clr_v[!proc] = bus_wdata[LO_LSB +: NCH];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.tx_en <= '0;
            cfg_q.rx_en <= '0;
            cfg_q.fm    <= '1;
            cfg_q.om    <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            case (slot)
                SLOT_CTRL: begin
                    bus_rdata[HI_LSB] = cfg_q.tx_en[proc];
                    bus_rdata[LO_LSB] = cfg_q.rx_en[proc];
                end
                SLOT_MASK: begin
                    bus_rdata[HI_LSB +: NCH] = cfg_q.fm[proc];
                    bus_rdata[LO_LSB +: NCH] = cfg_q.om[proc];
                end
                SLOT_STATUS: bus_rdata[LO_LSB +: NCH] = flags_w[proc];
                default: ;
            endcase
        end
    end

    assign tx_en_w = cfg_q.tx_en;
    assign rx_en_w = cfg_q.rx_en;
    assign fm_w    = cfg_q.fm;
    assign om_w    = cfg_q.om;

    generate
        for (genvar d = 0; d < NPROC; d++) begin : g_dir
            mbx_chan_flags #(.NCH(NCH)) u_flags (
                .clk(clk), .rst_n(rst_n),
                .set_i(set_v[d]), .clr_i(clr_v[d]), .flag_o(flags_w[d])
            );
        end
        for (genvar p = 0; p < NPROC; p++) begin : g_proc
            mbx_irq_gen #(.NCH(NCH), .FIRE_ON_SET(1'b0)) u_txfree (
                .clk(clk), .rst_n(rst_n), .en_i(tx_en_w[p]),
                .mask_i(fm_w[p]), .flag_i(flags_w[p]), .irq_o(irq_tx_w[p])
            );
            mbx_irq_gen #(.NCH(NCH), .FIRE_ON_SET(1'b1)) u_rxocc (
                .clk(clk), .rst_n(rst_n), .en_i(rx_en_w[p]),
                .mask_i(om_w[p]), .flag_i(flags_w[NPROC-1-p]), .irq_o(irq_rx_w[p])
            );
        end
    endgenerate

    assign p1_txfree_irq = irq_tx_w[0];
    assign p1_rxocc_irq  = irq_rx_w[0];
    assign p2_txfree_irq = irq_tx_w[1];
    assign p2_rxocc_irq  = irq_rx_w[1];

    logic unused_ok;
    assign unused_ok = ^bus_wdata;
endmodule

// File: rtl/mbx_flag_ctrl_chk.sv
module mbx_flag_ctrl_chk #(
    parameter int NCH = 6,
    parameter int ADDR_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_write,
    input logic [2:0]            bus_size,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic [1:0][NCH-1:0]   flags,
    input logic [1:0]            tx_en,
    input logic [1:0]            rx_en,
    input logic [1:0][NCH-1:0]   fm,
    input logic [1:0][NCH-1:0]   om,
    input logic [1:0]            irq_tx,
    input logic [1:0]            irq_rx
);
    logic wr_word, wr_narrow, wr_status, rd_setclr;
    logic [1:0] sc_wr;

    assign wr_word   = bus_sel && bus_write && (bus_size == 3'b010);
    assign wr_narrow = bus_sel && bus_write && (bus_size != 3'b010);
    assign sc_wr[0]  = wr_word && (bus_addr == ADDR_W'(8));
    assign sc_wr[1]  = wr_word && (bus_addr == ADDR_W'(24));
    assign wr_status = wr_word && ((bus_addr == ADDR_W'(12)) || (bus_addr == ADDR_W'(28)));
    assign rd_setclr = bus_sel && !bus_write && ((bus_addr == ADDR_W'(8)) || (bus_addr == ADDR_W'(24)));

    generate
        for (genvar p = 0; p < 2; p++) begin : g_p
            // R2: a flag rises only where its sender wrote a set bit
            a_r2_set_source: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> ((flags[p] & ~$past(flags[p])
                            & ~$past(sc_wr[p] ? bus_wdata[16 +: NCH] : {NCH{1'b0}})) == '0));
            // R3: a flag falls only where its receiver wrote a clear bit
            a_r3_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> ((~flags[p] & $past(flags[p])
                            & ~$past(sc_wr[1-p] ? bus_wdata[0 +: NCH] : {NCH{1'b0}})) == '0));
            // R6, R8: TX-free equation, one cycle late
            a_r6_txfree: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (irq_tx[p] == $past(tx_en[p] && ((~flags[p] & ~fm[p]) != '0))));
            // R7, R8: RX-occupied equation, one cycle late
            a_r7_rxocc: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (irq_rx[p] == $past(rx_en[p] && ((flags[1-p] & ~om[p]) != '0))));
        end
    endgenerate

    a_r9_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_narrow |=> $stable(flags));
    a_r5_status_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> $stable(flags));
    a_r4_setclr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_setclr |-> (bus_rdata == 32'h0));
endmodule

bind mbx_flag_ctrl mbx_flag_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flags(flags_w), .tx_en(tx_en_w), .rx_en(rx_en_w),
    .fm(fm_w), .om(om_w), .irq_tx(irq_tx_w), .irq_rx(irq_rx_w)
);

// File: tb/mbx_flag_ctrl_tb.sv
module mbx_flag_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_size = 3'b010;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic p1_txfree_irq, p1_rxocc_irq, p2_txfree_irq, p2_rxocc_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbx_flag_ctrl #(.NCH(6), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .p1_txfree_irq(p1_txfree_irq), .p1_rxocc_irq(p1_rxocc_irq),
        .p2_txfree_irq(p2_txfree_irq), .p2_rxocc_irq(p2_rxocc_irq)
    );

    // irq nibble: {p2_rxocc, p2_txfree, p1_rxocc, p1_txfree}
    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [2:0]  sz;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  irq;    // expected interrupts after the step
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h004, 3'd2, 32'h003F003F, 4'h0, 4'd1},  // R1
        '{1'b0, 12'h00C, 3'd2, 32'h00000000, 4'h0, 4'd1},  // R1
        '{1'b0, 12'h01C, 3'd2, 32'h00000000, 4'h0, 4'd1},  // R1
        '{1'b1, 12'h000, 3'd2, 32'h00010001, 4'h0, 4'd10}, // R10
        '{1'b1, 12'h004, 3'd2, 32'h003E003F, 4'h1, 4'd6},  // R6
        '{1'b1, 12'h008, 3'd2, 32'h00000000, 4'h1, 4'd2},  // R2 zero write
        '{1'b0, 12'h00C, 3'd2, 32'h00000000, 4'h1, 4'd2},  // R2
        '{1'b1, 12'h008, 3'd2, 32'h00010000, 4'h0, 4'd2},  // R2 set ch0
        '{1'b0, 12'h00C, 3'd2, 32'h00000001, 4'h0, 4'd2},  // R2
        '{1'b1, 12'h010, 3'd2, 32'h00000001, 4'h0, 4'd7},  // R7
        '{1'b1, 12'h014, 3'd2, 32'h003F003E, 4'h8, 4'd7},  // R7
        '{1'b0, 12'h014, 3'd2, 32'h003F003E, 4'h8, 4'd10}, // R10
        '{1'b1, 12'h018, 3'd2, 32'h00000001, 4'h1, 4'd3},  // R3 P2 clears ch0
        '{1'b0, 12'h00C, 3'd2, 32'h00000000, 4'h1, 4'd3},  // R3
        '{1'b0, 12'h008, 3'd2, 32'h00000000, 4'h1, 4'd4},  // R4
        '{1'b1, 12'h00C, 3'd2, 32'h0000003F, 4'h1, 4'd5},  // R5
        '{1'b0, 12'h00C, 3'd2, 32'h00000000, 4'h1, 4'd5},  // R5
        '{1'b1, 12'h008, 3'd0, 32'h00010000, 4'h1, 4'd9},  // R9 byte
        '{1'b1, 12'h008, 3'd1, 32'h00010000, 4'h1, 4'd9},  // R9 half
        '{1'b0, 12'h00C, 3'd2, 32'h00000000, 4'h1, 4'd9},  // R9
        '{1'b1, 12'h018, 3'd2, 32'h00200000, 4'h1, 4'd2},  // R2 P2 sets ch5
        '{1'b0, 12'h01C, 3'd2, 32'h00000020, 4'h1, 4'd2},  // R2
        '{1'b1, 12'h004, 3'd2, 32'h003E001F, 4'h3, 4'd7},  // R7
        '{1'b1, 12'h000, 3'd2, 32'h00000001, 4'h2, 4'd6},  // R6 enable gate
        '{1'b0, 12'h000, 3'd2, 32'h00000001, 4'h2, 4'd10}, // R10
        '{1'b1, 12'h000, 3'd2, 32'hFFFEFFFE, 4'h0, 4'd10}, // R10 reserved
        '{1'b0, 12'h000, 3'd2, 32'h00000000, 4'h0, 4'd10}, // R10
        '{1'b1, 12'h010, 3'd2, 32'h00010000, 4'h0, 4'd6},  // R6
        '{1'b1, 12'h014, 3'd2, 32'h001F003E, 4'h0, 4'd6},  // R6 flag still 1
        '{1'b1, 12'h008, 3'd2, 32'h00000020, 4'h4, 4'd3},  // R3 P1 clears ch5
        '{1'b0, 12'h01C, 3'd2, 32'h00000000, 4'h4, 4'd3},  // R3
        '{1'b0, 12'h020, 3'd2, 32'h00000000, 4'h4, 4'd11}, // R11
        '{1'b0, 12'h0A0, 3'd2, 32'h00000000, 4'h4, 4'd11}  // R11
    };

    function automatic logic [3:0] irqs();
        return {p2_rxocc_irq, p2_txfree_irq, p1_rxocc_irq, p1_txfree_irq};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at negedge, write sampled at next posedge, return at following negedge.
    task automatic bus_wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0; bus_size = 3'b010;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = 3'b010;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check(irqs() == 4'h0, "R1", "irqs in reset", {28'h0, irqs()}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irqs() == 4'h0, "R1", "irqs after reset", {28'h0, irqs()}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) begin
                bus_wr(TBL[i].addr, TBL[i].sz, TBL[i].data);
                @(negedge clk);  // interrupt register settles one clock later
            end else begin
                bus_rd(TBL[i].addr, rd);
                check(rd == TBL[i].data, $sformatf("R%0d", TBL[i].req),
                      $sformatf("read step %0d", i), rd, TBL[i].data);
            end
            check(irqs() == TBL[i].irq, $sformatf("R%0d", TBL[i].req),
                  $sformatf("irqs step %0d", i), {28'h0, irqs()}, {28'h0, TBL[i].irq});
        end

        // R8: latency. P2 sets ch5, which drops P2 TX-free one clock after the flag.
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 12'h018; bus_size = 3'b010;
        bus_wdata = 32'h00200000;
        @(negedge clk);
        bus_sel = 1'b0;
        check(irqs() == 4'h4, "R8", "irq before update", {28'h0, irqs()}, 32'h4);
        @(negedge clk);
        check(irqs() == 4'h0, "R8", "irq after update", {28'h0, irqs()}, 32'h0);

        // R1: mid-run reset restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(12'h014, rd);
        check(rd == 32'h003F003F, "R1", "P2 mask after reset", rd, 32'h003F003F);
        bus_rd(12'h01C, rd);
        check(rd == 32'h0, "R1", "P2 status after reset", rd, 32'h0);
        bus_rd(12'h010, rd);
        check(rd == 32'h0, "R1", "P2 ctrl after reset", rd, 32'h0);
        check(irqs() == 4'h0, "R1", "irqs after reset", {28'h0, irqs()}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule